// File: doc/BRIEF.md
# Synchronized clock stop controller

This block sits between a clock synthesizer's generated clocks and the output pins. It stops and restarts groups of those clocks for power management. Three active-low request pins drive it: halt the CPU clocks, halt the gated PCI clocks, and put the whole generator to sleep. A static strap decides whether the request pins count at all. When the strap is high, the pins are treated as ordinary clock pins and the requests are ignored.

Each clock group has its own gate cell, which runs in that group's own clock domain. Inside the cell, the request passes through a multi-flop synchronizer. A falling-edge enable flop then applies it, so a clock is only ever cut or resumed while it is low. As a result, every gated output is parked low and no runt pulse can occur.

The free-running PCI clock, the AGP clocks and the reference clock are exempt from both halt requests and stop only in sleep. Sleep is handled in an always-on control domain. A sequencer first drops the oscillator enable and the PLL enable. On wake it raises them one after the other and holds every output low until a settle count expires. That count stands in for the crystal start-up time and the PLL lock time.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n_i` is low, every clock output is low and both `osc_en_o` and `pll_en_o` are low.
- R2: With `pm_strap_i` low, driving `cpu_halt_req_n_i` low stops all CPU outputs in the low state. After the request, exactly two more CPU output rising edges appear, counted from the first input rising edge at or after the request. The third edge is suppressed.
- R3: When `cpu_halt_req_n_i` returns high, the first CPU output rising edge coincides with the third CPU input rising edge after the release.
- R4: With `pm_strap_i` low, driving `pci_halt_req_n_i` low stops the gated PCI outputs with the same two-edge latency in the PCI domain. `pci_free_clk_o` keeps toggling.
- R5: The AGP outputs, the reference output and `pci_free_clk_o` keep toggling while either halt request, or both, are active.
- R6: With `pm_strap_i` low, driving `sleep_req_n_i` low stops every clock output low and drives `osc_en_o` and `pll_en_o` low.
- R7: After sleep is released, or after reset, `osc_en_o` rises first. `pll_en_o` rises `OSC_SETTLE` control cycles later. All clock outputs stay low until a further `PLL_SETTLE` control cycles have passed, then all run.
- R8: While `pm_strap_i` is high, the three request pins have no effect: all outputs run and both enables stay high.
- R9: Every high phase of a clock output lasts at least half its input period. Every low phase between two output pulses also lasts at least half its input period, even when requests toggle asynchronously.
- R10: `pll_en_o` is never high while `osc_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n_i | input | 1 | Asynchronous active-low reset, release synchronized per domain |
| aon_clk_i | input | 1 | Always-on control clock for the sleep sequencer |
| pm_strap_i | input | 1 | Low: request pins are honoured; high: requests ignored |
| cpu_halt_req_n_i | input | 1 | Asynchronous active-low CPU clock halt request |
| pci_halt_req_n_i | input | 1 | Asynchronous active-low gated PCI clock halt request |
| sleep_req_n_i | input | 1 | Asynchronous active-low sleep request |
| cpu_clk_i | input | 1 | Internal CPU clock |
| pci_clk_i | input | 1 | Internal PCI clock for the gated outputs |
| pci_free_clk_i | input | 1 | Internal free-running PCI clock |
| agp_clk_i | input | 1 | Internal AGP clock |
| ref_clk_i | input | 1 | Internal reference clock |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| pci_free_clk_o | output | 1 | Free-running PCI clock, stopped only in sleep |
| agp_clk_o | output | N_AGP | AGP clocks, stopped only in sleep |
| ref_clk_o | output | 1 | Reference clock, stopped only in sleep |
| osc_en_o | output | 1 | Reference oscillator enable |
| pll_en_o | output | 1 | PLL enable |

## Verification
The halt properties sample at the falling edge of each input clock and look back three samples. They therefore assume that a request level, once applied, holds for at least one full period of the domain it halts. They also assume that the strap does not move while a request is active. The stimulus keeps to this in three ways. It changes the strap only while all request pins are idle. It spaces the random asynchronous request edges between 35 ns and 120 ns apart, which exceeds the slowest halted period of 30 ns. It aligns the latency measurements to a fixed offset after an input rising edge.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Control-domain sequencer states for sleep entry and wake.
  typedef enum logic [1:0] {
    PW_OFF = 2'd0,
    PW_OSC = 2'd1,
    PW_PLL = 2'd2,
    PW_ON  = 2'd3
  } pw_state_e;

  // Width of a counter that must reach value n-1.
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= {STAGES{RST_VAL}};
    else          chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             halt_i,
  output logic [WIDTH-1:0] clk_o
);

  logic lrst_n;
  logic halt_s;
  logic en_q;
  logic en_d;
  logic en_ce;

  // Local reset: asserts at once, releases on this domain's clock.
  clkstop_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .d_i     (1'b1),
    .q_o     (lrst_n)
  );

  // Halt request brought into this domain; resets to halted.
  clkstop_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_halt (
    .clk_i   (clk_i),
    .rst_n_i (lrst_n),
    .d_i     (halt_i),
    .q_o     (halt_s)
  );

  always_comb begin
    en_d  = ~halt_s;
    en_ce = (en_d != en_q);
  end

  // Enable moves only on the falling edge, i.e. while the clock is low.
  always_ff @(negedge clk_i or negedge lrst_n) begin
    if (!lrst_n)    en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_out
      assign clk_o[i] = clk_i & en_q;
    end
  endgenerate

endmodule

// File: rtl/clkstop_pwr.sv
module clkstop_pwr
  import clkstop_pkg::*;
#(
  parameter int unsigned OSC_SETTLE = 32,
  parameter int unsigned PLL_SETTLE = 32,
  parameter int unsigned STAGES     = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic sleep_i,
  output logic osc_en_o,
  output logic pll_en_o,
  output logic hold_o
);

  localparam int unsigned MAXC = (OSC_SETTLE > PLL_SETTLE) ? OSC_SETTLE : PLL_SETTLE;
  localparam int unsigned CW   = cnt_w(MAXC);
  localparam logic [CW-1:0] OSC_LAST = CW'(OSC_SETTLE - 1);
  localparam logic [CW-1:0] PLL_LAST = CW'(PLL_SETTLE - 1);

  logic      lrst_n;
  logic      sleep_s;
  pw_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic      cnt_ce;
  logic      osc_q, pll_q, hold_q;

  clkstop_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .d_i     (1'b1),
    .q_o     (lrst_n)
  );

  clkstop_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sleep (
    .clk_i   (clk_i),
    .rst_n_i (lrst_n),
    .d_i     (sleep_i),
    .q_o     (sleep_s)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_ce  = 1'b0;
    if (sleep_s) begin
      state_d = PW_OFF;
      cnt_d   = '0;
      cnt_ce  = (cnt_q != '0);
    end else begin
      unique case (state_q)
        PW_OFF: begin
          state_d = PW_OSC;
          cnt_d   = '0;
          cnt_ce  = 1'b1;
        end
        PW_OSC: begin
          cnt_ce = 1'b1;
          if (cnt_q == OSC_LAST) begin
            state_d = PW_PLL;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PW_PLL: begin
          cnt_ce = 1'b1;
          if (cnt_q == PLL_LAST) begin
            state_d = PW_ON;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PW_ON: begin
          state_d = PW_ON;
        end
        default: state_d = PW_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge lrst_n) begin
    if (!lrst_n) begin
      state_q <= PW_OFF;
      cnt_q   <= '0;
      osc_q   <= 1'b0;
      pll_q   <= 1'b0;
      hold_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (cnt_ce) cnt_q <= cnt_d;
      osc_q  <= (state_d != PW_OFF);
      pll_q  <= (state_d == PW_PLL) || (state_d == PW_ON);
      hold_q <= (state_d != PW_ON);
    end
  end

  assign osc_en_o = osc_q;
  assign pll_en_o = pll_q;
  assign hold_o   = hold_q;

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int unsigned N_CPU      = 4,
  parameter int unsigned N_PCI      = 4,
  parameter int unsigned N_AGP      = 2,
  parameter int unsigned STAGES     = 2,
  parameter int unsigned OSC_SETTLE = 32,
  parameter int unsigned PLL_SETTLE = 32
) (
  input  logic             rst_n_i,
  input  logic             aon_clk_i,
  input  logic             pm_strap_i,
  input  logic             cpu_halt_req_n_i,
  input  logic             pci_halt_req_n_i,
  input  logic             sleep_req_n_i,
  input  logic             cpu_clk_i,
  input  logic             pci_clk_i,
  input  logic             pci_free_clk_i,
  input  logic             agp_clk_i,
  input  logic             ref_clk_i,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic [N_PCI-1:0] pci_clk_o,
  output logic             pci_free_clk_o,
  output logic [N_AGP-1:0] agp_clk_o,
  output logic             ref_clk_o,
  output logic             osc_en_o,
  output logic             pll_en_o
);

  logic pm_on;
  logic cpu_req, pci_req, sleep_req;
  logic hold;
  logic cpu_halt, pci_halt;

  // Requests count only while the strap selects power management.
  always_comb begin
    pm_on     = ~pm_strap_i;
    cpu_req   = pm_on & ~cpu_halt_req_n_i;
    pci_req   = pm_on & ~pci_halt_req_n_i;
    sleep_req = pm_on & ~sleep_req_n_i;
    cpu_halt  = hold | cpu_req;
    pci_halt  = hold | pci_req;
  end

  clkstop_pwr #(
    .OSC_SETTLE (OSC_SETTLE),
    .PLL_SETTLE (PLL_SETTLE),
    .STAGES     (STAGES)
  ) u_pwr (
    .clk_i    (aon_clk_i),
    .rst_n_i  (rst_n_i),
    .sleep_i  (sleep_req),
    .osc_en_o (osc_en_o),
    .pll_en_o (pll_en_o),
    .hold_o   (hold)
  );

  clkstop_gate #(.WIDTH(N_CPU), .STAGES(STAGES)) u_cpu (
    .clk_i (cpu_clk_i), .rst_n_i (rst_n_i), .halt_i (cpu_halt), .clk_o (cpu_clk_o)
  );

  clkstop_gate #(.WIDTH(N_PCI), .STAGES(STAGES)) u_pci (
    .clk_i (pci_clk_i), .rst_n_i (rst_n_i), .halt_i (pci_halt), .clk_o (pci_clk_o)
  );

  clkstop_gate #(.WIDTH(1), .STAGES(STAGES)) u_pcif (
    .clk_i (pci_free_clk_i), .rst_n_i (rst_n_i), .halt_i (hold), .clk_o (pci_free_clk_o)
  );

  clkstop_gate #(.WIDTH(N_AGP), .STAGES(STAGES)) u_agp (
    .clk_i (agp_clk_i), .rst_n_i (rst_n_i), .halt_i (hold), .clk_o (agp_clk_o)
  );

  clkstop_gate #(.WIDTH(1), .STAGES(STAGES)) u_ref (
    .clk_i (ref_clk_i), .rst_n_i (rst_n_i), .halt_i (hold), .clk_o (ref_clk_o)
  );

endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
  parameter int unsigned N_CPU = 4,
  parameter int unsigned N_PCI = 4,
  parameter int unsigned N_AGP = 2
) (
  input logic             rst_n_i,
  input logic             aon_clk_i,
  input logic             pm_strap_i,
  input logic             cpu_halt_req_n_i,
  input logic             pci_halt_req_n_i,
  input logic             cpu_clk_i,
  input logic             pci_clk_i,
  input logic [N_CPU-1:0] cpu_clk_o,
  input logic [N_PCI-1:0] pci_clk_o,
  input logic             pci_free_clk_o,
  input logic [N_AGP-1:0] agp_clk_o,
  input logic             ref_clk_o,
  input logic             osc_en_o,
  input logic             pll_en_o
);

  localparam int unsigned QUIET_WIN = 40;

  logic [7:0] off_cnt_q;
  logic cpu_stop_c, pci_stop_c;

  assign cpu_stop_c = ~pm_strap_i & ~cpu_halt_req_n_i;
  assign pci_stop_c = ~pm_strap_i & ~pci_halt_req_n_i;

  // Control cycles since the oscillator enable last went low.
  always_ff @(posedge aon_clk_i or negedge rst_n_i) begin
    if (!rst_n_i)                 off_cnt_q <= '0;
    else if (osc_en_o)            off_cnt_q <= '0;
    else if (off_cnt_q < QUIET_WIN) off_cnt_q <= off_cnt_q + 1'b1;
  end

  // R10
  assert_pll_needs_osc_R10: assert property (@(posedge aon_clk_i) disable iff (!rst_n_i)
    pll_en_o |-> osc_en_o);

  // R7
  assert_osc_before_pll_R7: assert property (@(posedge aon_clk_i) disable iff (!rst_n_i)
    $rose(pll_en_o) |-> $past(osc_en_o));

  // R6
  assert_sleep_quiet_R6: assert property (@(posedge aon_clk_i) disable iff (!rst_n_i)
    (off_cnt_q == QUIET_WIN) |->
      (cpu_clk_o == '0 && pci_clk_o == '0 && agp_clk_o == '0 && !pci_free_clk_o && !ref_clk_o));

  // R2: sampled at the falling edge, the value seen is the high phase just ending.
  assert_cpu_halt_R2: assert property (@(negedge cpu_clk_i) disable iff (!rst_n_i)
    (cpu_stop_c && $past(cpu_stop_c) && $past(cpu_stop_c, 2) && $past(cpu_stop_c, 3))
      |-> (cpu_clk_o == '0));

  // R4
  assert_pci_halt_R4: assert property (@(negedge pci_clk_i) disable iff (!rst_n_i)
    (pci_stop_c && $past(pci_stop_c) && $past(pci_stop_c, 2) && $past(pci_stop_c, 3))
      |-> (pci_clk_o == '0));

endmodule

bind clkstop_ctrl clkstop_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_AGP(N_AGP)) u_chk (
  .rst_n_i          (rst_n_i),
  .aon_clk_i        (aon_clk_i),
  .pm_strap_i       (pm_strap_i),
  .cpu_halt_req_n_i (cpu_halt_req_n_i),
  .pci_halt_req_n_i (pci_halt_req_n_i),
  .cpu_clk_i        (cpu_clk_i),
  .pci_clk_i        (pci_clk_i),
  .cpu_clk_o        (cpu_clk_o),
  .pci_clk_o        (pci_clk_o),
  .pci_free_clk_o   (pci_free_clk_o),
  .agp_clk_o        (agp_clk_o),
  .ref_clk_o        (ref_clk_o),
  .osc_en_o         (osc_en_o),
  .pll_en_o         (pll_en_o)
);

// File: tb/tb_clkstop_ctrl.sv
`timescale 1ns/1ps

module tb_clkstop_pw #(
  parameter int HALF_NS = 8,
  parameter string NAME = "clk"
) (
  input logic clk
);
  int checks = 0;
  int fails  = 0;
  realtime t_rise, t_fall;
  bit seen_fall = 0;
  bit seen_rise = 0;

  // R9: high and low phases no shorter than half the input period.
  always @(posedge clk) begin
    if (seen_fall) begin
      checks++;
      if ($realtime - t_fall < HALF_NS - 0.1) begin
        fails++;
        $display("FAIL R9 %s low phase actual=%0t expected>=%0d ns", NAME, $realtime - t_fall, HALF_NS);
      end
    end
    t_rise = $realtime;
    seen_rise = 1;
  end

  always @(negedge clk) begin
    if (seen_rise) begin
      checks++;
      if ($realtime - t_rise < HALF_NS - 0.1) begin
        fails++;
        $display("FAIL R9 %s high phase actual=%0t expected>=%0d ns", NAME, $realtime - t_rise, HALF_NS);
      end
    end
    t_fall = $realtime;
    seen_fall = 1;
  end
endmodule

module tb_clkstop_ctrl;
  localparam int N_CPU = 4, N_PCI = 4, N_AGP = 2;
  localparam int TOT = N_CPU + N_PCI + 1 + N_AGP + 1;
  localparam int WIN = 200;
  localparam int GLO [5] = '{0, N_CPU, N_CPU+N_PCI, N_CPU+N_PCI+1, TOT-1};
  localparam int GHI [5] = '{N_CPU-1, N_CPU+N_PCI-1, N_CPU+N_PCI, TOT-2, TOT-1};

  logic rst_n = 0, aon_clk = 0, strap = 0;
  logic cpu_req_n = 1, pci_req_n = 1, sleep_n = 1;
  logic cpu_clk = 0, pci_clk = 0, pcif_clk = 0, agp_clk = 0, ref_clk = 0;
  logic [N_CPU-1:0] cpu_o;
  logic [N_PCI-1:0] pci_o;
  logic pcif_o, ref_o, osc_en, pll_en;
  logic [N_AGP-1:0] agp_o;

  always #5  aon_clk = ~aon_clk;
  always #8  cpu_clk = ~cpu_clk;
  always #15 pci_clk = ~pci_clk;
  initial begin #4; forever #15 pcif_clk = ~pcif_clk; end
  initial begin #3; forever #8  agp_clk  = ~agp_clk;  end
  always #35 ref_clk = ~ref_clk;

  clkstop_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_AGP(N_AGP)) dut (
    .rst_n_i (rst_n), .aon_clk_i (aon_clk), .pm_strap_i (strap),
    .cpu_halt_req_n_i (cpu_req_n), .pci_halt_req_n_i (pci_req_n), .sleep_req_n_i (sleep_n),
    .cpu_clk_i (cpu_clk), .pci_clk_i (pci_clk), .pci_free_clk_i (pcif_clk),
    .agp_clk_i (agp_clk), .ref_clk_i (ref_clk),
    .cpu_clk_o (cpu_o), .pci_clk_o (pci_o), .pci_free_clk_o (pcif_o),
    .agp_clk_o (agp_o), .ref_clk_o (ref_o), .osc_en_o (osc_en), .pll_en_o (pll_en)
  );

  tb_clkstop_pw #(.HALF_NS(8),  .NAME("cpu"))  pw_cpu  (.clk(cpu_o[0]));
  tb_clkstop_pw #(.HALF_NS(15), .NAME("pci"))  pw_pci  (.clk(pci_o[0]));
  tb_clkstop_pw #(.HALF_NS(15), .NAME("pcif")) pw_pcif (.clk(pcif_o));
  tb_clkstop_pw #(.HALF_NS(8),  .NAME("agp"))  pw_agp  (.clk(agp_o[0]));
  tb_clkstop_pw #(.HALF_NS(35), .NAME("ref"))  pw_ref  (.clk(ref_o));

  wire [TOT-1:0] all_o = {ref_o, agp_o, pcif_o, pci_o, cpu_o};
  int cnt [TOT];
  initial for (int i = 0; i < TOT; i++) cnt[i] = 0;
  generate
    for (genvar g = 0; g < TOT; g++) begin : g_cnt
      always @(posedge all_o[g]) cnt[g] = cnt[g] + 1;
    end
  endgenerate

  int vectors = 0, miscompares = 0;

  typedef struct {
    string      tag;
    logic [4:0] run;   // cpu, pci, pcif, agp, ref: 1 running, 0 stopped
    logic       osc;
    logic       pll;
  } exp_t;
  exp_t sb_q [$];

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver side of the scoreboard.
  task automatic expect_state(input string tag, input logic [4:0] run, input logic osc, input logic pll);
    exp_t it;
    it.tag = tag; it.run = run; it.osc = osc; it.pll = pll;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  // Monitor: measure edge activity of each group over a window.
  initial begin
    int snap [TOT];
    forever begin
      exp_t it;
      wait (sb_q.size() != 0);
      it = sb_q[0];
      for (int i = 0; i < TOT; i++) snap[i] = cnt[i];
      #(WIN);
      for (int g = 0; g < 5; g++) begin
        int mn, mx, code;
        mn = 1000; mx = 0;
        for (int i = GLO[g]; i <= GHI[g]; i++) begin
          int d;
          d = cnt[i] - snap[i];
          if (d < mn) mn = d;
          if (d > mx) mx = d;
        end
        code = (mx == 0) ? 0 : ((mn >= 2) ? 1 : 2);
        chk($sformatf("%s group%0d run", it.tag, g), code, int'(it.run[4-g]));
      end
      chk($sformatf("%s osc_en", it.tag), int'(osc_en), int'(it.osc));
      chk($sformatf("%s pll_en", it.tag), int'(pll_en), int'(it.pll));
      void'(sb_q.pop_front());
    end
  end

  task automatic in_edge(input bit is_cpu);
    if (is_cpu) @(posedge cpu_clk); else @(posedge pci_clk);
  endtask

  // Aligned latency measurement of halt entry (2 edges pass) and exit (3rd edge first).
  task automatic latency(input bit is_cpu, input string tag_on, input string tag_off);
    int idx, c0;
    idx = is_cpu ? 0 : N_CPU;
    in_edge(is_cpu); #2;
    c0 = cnt[idx];
    if (is_cpu) cpu_req_n = 0; else pci_req_n = 0;
    repeat (5) in_edge(is_cpu);
    #2;
    chk({tag_on, " edges after halt"}, cnt[idx] - c0, 2);
    c0 = cnt[idx];
    if (is_cpu) cpu_req_n = 1; else pci_req_n = 1;
    repeat (2) in_edge(is_cpu);
    #2;
    chk({tag_off, " no edge before third"}, cnt[idx] - c0, 0);
    in_edge(is_cpu); #2;
    chk({tag_off, " edge on third"}, cnt[idx] - c0, 1);
  endtask

  task automatic run_all();
    // R1: reset state
    #20;
    expect_state("R1 reset", 5'b00000, 0, 0);
    #(300 - $realtime);
    rst_n = 1;
    // R7: wake after reset, oscillator up, PLL not yet, outputs held
    #60;
    expect_state("R7 after reset settle", 5'b00000, 1, 0);
    #1000;
    expect_state("R7 after reset run", 5'b11111, 1, 1);

    // R2, R3 latency on CPU; R4 latency on PCI
    latency(1'b1, "R2", "R3");
    latency(1'b0, "R4", "R4 resume");

    // R2 and R5: CPU halted only
    cpu_req_n = 0; #200;
    expect_state("R2 R5 cpu halted", 5'b01111, 1, 1);
    // R4 and R5: both halted, exempt clocks run
    pci_req_n = 0; #200;
    expect_state("R4 R5 both halted", 5'b00111, 1, 1);
    cpu_req_n = 1; #200;
    expect_state("R4 pci halted", 5'b10111, 1, 1);
    pci_req_n = 1; #200;
    expect_state("R3 R4 resumed", 5'b11111, 1, 1);

    // R9: random asynchronous request edges
    for (int k = 0; k < 60; k++) begin
      #($urandom_range(35, 120));
      if ($urandom_range(0, 1) == 1) cpu_req_n = ~cpu_req_n;
      else                           pci_req_n = ~pci_req_n;
    end
    cpu_req_n = 1; pci_req_n = 1; #200;
    expect_state("R9 after random", 5'b11111, 1, 1);

    // R8: strap high, all request pins low, nothing stops
    strap = 1; #50;
    cpu_req_n = 0; pci_req_n = 0; sleep_n = 0; #500;
    expect_state("R8 strap high", 5'b11111, 1, 1);
    cpu_req_n = 1; pci_req_n = 1; sleep_n = 1; #50;
    strap = 0; #100;

    // R6: sleep
    sleep_n = 0; #400;
    expect_state("R6 sleep", 5'b00000, 0, 0);
    // R7: wake sequencing
    sleep_n = 1; #60;
    expect_state("R7 wake settle", 5'b00000, 1, 0);
    #1000;
    expect_state("R7 wake run", 5'b11111, 1, 1);
  endtask

  initial begin
    bit wd_hit;
    wd_hit = 0;
    fork
      run_all();
      begin #200000; wd_hit = 1; end
    join_any
    disable fork;
    if (wd_hit) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    vectors     += pw_cpu.checks + pw_pci.checks + pw_pcif.checks + pw_agp.checks + pw_ref.checks;
    miscompares += pw_cpu.fails + pw_pci.fails + pw_pcif.fails + pw_agp.fails + pw_ref.fails;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule